// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers up to 32 interrupt lines from peripherals and presents them to a processor as one interrupt request. Software picks a trigger type for each line: level or edge, and which polarity. Captured events are held in a pending set. A per-line enable decides which pending lines can show up in the masked status and raise the request. Software reaches the block over a simple 32-bit read/write register bus that decodes a 4 KiB window.

Every raw line first passes through a multi-flop synchronizer. After that, an edge detector or a level sampler produces set events for the pending flops. A write-one-to-clear register discards pending events, and its effect depends on the trigger type. A level line that is still asserted returns one cycle after the clear. An edge event that arrives in the same cycle as its clear is kept.

Top module: `irqc_top`

## Requirements
- R1: Word registers sit at byte offsets 0x00 (synchronized raw inputs, read-only), 0x04 (enable), 0x08 (clear), 0x0C (trigger type), 0x10 (polarity) and 0x14 (masked status), with bit i belonging to source i.
- R2: A trigger-type bit of 1 makes its source edge-sensitive, and 0 makes it level-sensitive.
- R3: A polarity bit of 1 selects active-low (level) or falling-edge (edge), and 0 selects active-high or rising-edge.
- R4: Writing 1 to a clear bit discards that source's pending event. Writing 0 leaves it alone, and the clear offset reads as zero.
- R5: The status register shows only sources that are both pending and enabled. A disabled source still latches pending and appears in status once it is enabled.
- R6: After reset, all enables are 0, all pending bits are cleared, all trigger types are level (0) and all polarity bits are 1 (active-low).
- R7: Clearing a level source whose input is still asserted reads as not pending in the cycle after the clear write, and as pending again one cycle later.
- R8: A latched edge event stays pending after the input returns to idle, until it is cleared.
- R9: An edge event that reaches the pending flop in the same cycle as a clear of that bit stays pending.
- R10: The interrupt request output equals the OR of the status bits one clock cycle earlier.
- R11: A change on a source input appears in the raw register after two clock edges and in pending after the third.
- R12: Word addresses in the 4 KiB window other than the six registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Raw interrupt source lines, asynchronous |
| bus_en_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 12 | Byte address within the 4 KiB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: all 32 source lanes and a two-stage synchronizer. This means lane 31 and full-width masks are exercised, and the three-edge input-to-pending latency is fixed. It can therefore place an edge exactly on the cycle of a clear write, and it can observe the one-cycle gap before an asserted level source re-pends. The vector table mixes trigger types, polarities, idle states and enable masks across the lanes, and an independent per-lane model predicts the status.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;

    typedef enum logic [2:0] {
        REG_RAW  = 3'd0,
        REG_EN   = 3'd1,
        REG_CLR  = 3'd2,
        REG_MODE = 3'd3,
        REG_POL  = 3'd4,
        REG_STAT = 3'd5,
        REG_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [BUS_W-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        r = REG_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[ADDR_W-1:2])
                10'd0:   r = REG_RAW;
                10'd1:   r = REG_EN;
                10'd2:   r = REG_CLR;
                10'd3:   r = REG_MODE;
                10'd4:   r = REG_POL;
                10'd5:   r = REG_STAT;
                default: r = REG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] s,
    input  logic [W-1:0] pol,
    output logic [W-1:0] act,
    output logic [W-1:0] edge_evt
);
    logic [W-1:0] act_q;

    // polarity 1 inverts the line so that "asserted" is always high here
    assign act = s ^ pol;

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= act;
    end

    assign edge_evt = act & ~act_q;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] act,
    input  logic [W-1:0] edge_evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pending
);
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_lane
        always_comb begin
            if (mode[i]) nxt[i] = (pending[i] & ~clr[i]) | edge_evt[i];
            else         nxt[i] = clr[i] ? 1'b0 : (pending[i] | act[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= nxt;
    end

    // R7
    level_clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~mode)) |=> ((pending & $past(clr & ~mode)) == '0));

    // R9
    edge_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (|(edge_evt & mode)) |=> ((pending & $past(edge_evt & mode)) == $past(edge_evt & mode)));

    // R8
    edge_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (|(pending & mode & ~clr)) |=> ((pending & $past(pending & mode & ~clr)) == $past(pending & mode & ~clr)));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              req_vld,
    input  reg_sel_e          rd_sel,
    input  logic [W-1:0]      raw,
    input  logic [W-1:0]      pending,
    output logic [W-1:0]      enable,
    output logic [W-1:0]      mode,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      clr,
    output logic [W-1:0]      status,
    output logic [BUS_W-1:0]  rdata
);
    logic         do_wr;
    logic [W-1:0] wd;

    assign do_wr  = req_vld & req.wr;
    assign wd     = req.data[W-1:0];
    assign clr    = (do_wr && req.sel == REG_CLR) ? wd : '0;
    assign status = pending & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            mode   <= '0;
            pol    <= '1;
        end else if (do_wr) begin
            case (req.sel)
                REG_EN:   enable <= wd;
                REG_MODE: mode   <= wd;
                REG_POL:  pol    <= wd;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (rd_sel)
            REG_RAW:  rdata[W-1:0] = raw;
            REG_EN:   rdata[W-1:0] = enable;
            REG_MODE: rdata[W-1:0] = mode;
            REG_POL:  rdata[W-1:0] = pol;
            REG_STAT: rdata[W-1:0] = status;
            default:  rdata = '0;
        endcase
    end

    // R6
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (enable == '0 && mode == '0 && pol == '1));

    // R1
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
        (do_wr && req.sel == REG_EN) |=> (enable == $past(wd)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_en_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    bus_req_t         req;
    reg_sel_e         sel;
    logic [N_SRC-1:0] raw, act, edge_evt, pending;
    logic [N_SRC-1:0] enable, mode, pol, clr, status;

    assign sel = decode_addr(bus_addr_i);
    assign req = '{wr: bus_wr_i, sel: sel, data: bus_wdata_i};

    irqc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(src_i), .q(raw)
    );

    irqc_detect #(.W(N_SRC)) u_detect (
        .clk(clk), .rst(rst), .s(raw), .pol(pol), .act(act), .edge_evt(edge_evt)
    );

    irqc_pending #(.W(N_SRC)) u_pending (
        .clk(clk), .rst(rst), .mode(mode), .act(act), .edge_evt(edge_evt),
        .clr(clr), .pending(pending)
    );

    irqc_regs #(.W(N_SRC)) u_regs (
        .clk(clk), .rst(rst), .req(req), .req_vld(bus_en_i), .rd_sel(sel),
        .raw(raw), .pending(pending), .enable(enable), .mode(mode), .pol(pol),
        .clr(clr), .status(status), .rdata(bus_rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |status;
    end

    // R10
    irq_follows_status_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|status)));

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |=> (irq_o == 1'b0));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src;
    logic        bus_en, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam logic [11:0] A_RAW = 12'h000, A_EN = 12'h004, A_CLR = 12'h008;
    localparam logic [11:0] A_MODE = 12'h00C, A_POL = 12'h010, A_STAT = 12'h014;

    // fields: mode, pol, enable, idle input, active input
    localparam int NV = 8;
    localparam logic [159:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h1234_5678},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_00FF},
        {32'h0000_FFFF, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h3333_3333},
        {32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    irqc_top i_irqc_top (
        .clk(clk), .rst(rst), .src_i(src), .bus_en_i(bus_en), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-lane prediction after idle -> active -> idle with a clear at idle
    function automatic logic [31:0] model(input logic [31:0] m, input logic [31:0] p,
                                          input logic [31:0] e, input logic [31:0] i,
                                          input logic [31:0] a);
        logic [31:0] lvl, edg;
        lvl = (i ^ p) | (a ^ p);
        edg = i ^ a;
        return e & ((m & edg) | (~m & lvl));
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, exp;
        rst = 1'b1; src = '0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_cyc(4);
        rst = 1'b0;
        @(negedge clk);
        // R6 reset state
        rd_reg(A_EN, v);   check("R6 enable", v, 32'h0);
        rd_reg(A_MODE, v); check("R6 mode", v, 32'h0);
        rd_reg(A_POL, v);  check("R6 polarity", v, 32'hFFFF_FFFF);
        rd_reg(A_STAT, v); check("R6 status", v, 32'h0);
        check("R6 irq", {31'h0, irq}, 32'h0);

        // table walk: R2 R3 R5 R10
        for (int k = 0; k < NV; k++) begin
            logic [31:0] m, p, e, i, a;
            {m, p, e, i, a} = VEC[k];
            wr_reg(A_EN, 32'h0);
            src = i;
            wr_reg(A_MODE, m);
            wr_reg(A_POL, p);
            wait_cyc(6);
            wr_reg(A_CLR, 32'hFFFF_FFFF);
            wr_reg(A_EN, e);
            src = a;
            wait_cyc(6);
            src = i;
            wait_cyc(6);
            exp = model(m, p, e, i, a);
            rd_reg(A_STAT, v);
            check($sformatf("R2 R3 R5 vector %0d status", k), v, exp);
            @(negedge clk);
            check($sformatf("R10 vector %0d irq", k), {31'h0, irq}, {31'h0, |exp});
        end

        // R11 synchronizer latency, R1 raw readback
        src = 32'h0;
        wait_cyc(4);
        src = 32'hDEAD_BEEF;
        @(negedge clk);
        rd_reg(A_RAW, v); check("R11 raw after one edge", v, 32'h0);
        @(negedge clk);
        rd_reg(A_RAW, v); check("R1 R11 raw after two edges", v, 32'hDEAD_BEEF);
        src = 32'h0;

        // edge source on lane 3: R8, R4
        wr_reg(A_EN, 32'h0);
        wr_reg(A_MODE, 32'h0000_0008);
        wr_reg(A_POL, 32'h0);
        wait_cyc(4);
        wr_reg(A_CLR, 32'hFFFF_FFFF);
        wr_reg(A_EN, 32'h0000_0008);
        src = 32'h8; wait_cyc(4); src = 32'h0; wait_cyc(4);
        rd_reg(A_STAT, v); check("R8 edge held after idle", v, 32'h8);
        wr_reg(A_CLR, 32'h0);
        rd_reg(A_STAT, v); check("R4 clear of zero ignored", v, 32'h8);
        rd_reg(A_CLR, v);  check("R4 clear reads zero", v, 32'h0);
        wr_reg(A_CLR, 32'h8);
        rd_reg(A_STAT, v); check("R4 clear of one", v, 32'h0);

        // R9 edge arriving with the clear write
        src = 32'h8;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h8;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        rd_reg(A_STAT, v); check("R9 edge wins over clear", v, 32'h8);
        src = 32'h0;
        wait_cyc(4);
        wr_reg(A_CLR, 32'hFFFF_FFFF);

        // R7 level re-pend on lane 5, active-high
        wr_reg(A_EN, 32'h0);
        wr_reg(A_MODE, 32'h0);
        wr_reg(A_POL, 32'h0);
        wait_cyc(4);
        wr_reg(A_CLR, 32'hFFFF_FFFF);
        wr_reg(A_EN, 32'h20);
        src = 32'h20; wait_cyc(4);
        rd_reg(A_STAT, v); check("R7 level pending", v, 32'h20);
        wr_reg(A_CLR, 32'h20);
        rd_reg(A_STAT, v); check("R7 cleared for one cycle", v, 32'h0);
        @(negedge clk);
        rd_reg(A_STAT, v); check("R7 pending again", v, 32'h20);

        // R5 disabled lane keeps pending; R10 irq one cycle behind status
        wr_reg(A_EN, 32'h0);
        rd_reg(A_STAT, v); check("R5 masked while disabled", v, 32'h0);
        wait_cyc(3);
        check("R5 irq quiet while disabled", {31'h0, irq}, 32'h0);
        wr_reg(A_EN, 32'h20);
        rd_reg(A_STAT, v); check("R5 latched shows on enable", v, 32'h20);
        check("R10 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq one cycle later", {31'h0, irq}, 32'h1);

        // R12 unmapped addresses
        rd_reg(12'h018, v); check("R12 unmapped 0x018", v, 32'h0);
        rd_reg(12'hFFC, v); check("R12 unmapped 0xFFC", v, 32'h0);

        // R6 reset again mid-run
        @(negedge clk);
        rst = 1'b1; wait_cyc(2); rst = 1'b0;
        @(negedge clk);
        rd_reg(A_EN, v);   check("R6 enable after reset", v, 32'h0);
        rd_reg(A_POL, v);  check("R6 polarity after reset", v, 32'hFFFF_FFFF);
        rd_reg(A_STAT, v); check("R6 status after reset", v, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule